// File: doc/BRIEF.md
# Recursive Ones-Counting Compressor

This block counts how many of its 2^N−1 single-bit inputs are set and presents that number as an N-bit unsigned binary value. A full input vector of ones produces an all-ones count. The block is meant for inner-product and neural-summation datapaths, where many binary product terms must be reduced to one small integer.

The datapath is built only from 3-2 cells, each a full adder. The 7-input level is written out directly from four cells. Every larger level splits its inputs into two halves of 2^(N−1)−1 bits and counts each half with a copy of the level below. The one leftover input becomes the carry-in of a ripple chain of N−1 cells, which adds the two sub-counts bit by bit. The final carry of that chain is the most significant bit of the count.

The width N is a parameter checked during elaboration. An optional output register can be enabled, and it is on by default.

Top module: `ones_counter`

## Requirements
- R1: Each 3-2 cell forms f = a XOR c, sum = f·¬b + ¬f·b and carry = f·b + ¬f·c. Its two outputs, {carry,sum}, equal the number of ones among a, b and c. For N = 3 this holds for all 128 input patterns.
- R2: For any input vector, the count equals the number of set bits in `din`.
- R3: An all-zero `din` yields a count of 0.
- R4: An all-ones `din` yields a count of 2^N−1, which has every bit of `count` set.
- R5: A `din` with exactly one bit set yields a count of 1, at every bit position. This includes the top bit, which is the leftover bit fed in as carry-in.
- R6: With OUT_REG = 1, `count` is 0 while `rst_n` is low. After reset, `count` holds the count of the `din` captured at the most recent rising edge of `clk`, and it does not change between edges.
- R7: Parameter N selects the size. N = 3, 4 and 7 give 7-, 15- and 127-input counters with 3-, 4- and 7-bit counts. N outside 3..10 is rejected during elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| din | input | 2^N−1 | Bits to be counted |
| count | output | N | Number of set bits in `din`, registered when OUT_REG = 1 |

## Verification
On every clock after reset, the assertions compare the registered count with the population count of the input captured one edge earlier. They also check the zero, full and one-hot input cases against their fixed results, and each 3-2 cell checks its two outputs against the arithmetic sum of its inputs. The bench scenarios are needed for the remaining behaviour. They hold `count` at zero during reset and show that `count` holds its value until the next clock edge. They also run the design at three different values of N, sweep a single set bit through every position (including the leftover carry-in bit), and cover the full 7-bit input space.

// File: rtl/ones_cnt_pkg.sv
package ones_cnt_pkg;
   // Smallest and largest supported count widths.
   localparam int MIN_WIDTH = 3;
   localparam int MAX_WIDTH = 10;

   // Number of input bits a counter of count width n accepts.
   function automatic int inputs_for(input int n);
      return (1 << n) - 1;
   endfunction

   // Number of 3-2 cells a counter of width n consumes.
   function automatic int cells_for(input int n);
      int total;
      total = 4;
      for (int k = 4; k <= n; k++) total = 2 * total + (k - 1);
      return total;
   endfunction
endpackage

// File: rtl/csa32_cell.sv
module csa32_cell (
   input  logic a,
   input  logic b,
   input  logic c,
   output logic s,
   output logic co
);
   logic f;

   always_comb begin
      f  = a ^ c;
      s  = (f & ~b) | (~f & b);
      co = (f & b) | (~f & c);
      // R1
      cell_sum_chk: assert ({co, s} == (2'(a) + 2'(b) + 2'(c)));
   end
endmodule

// File: rtl/ones_cnt_node.sv
module ones_cnt_node #(
   parameter int LVL = 3
) (
   input  logic [(2**LVL)-2:0] bits,
   output logic [LVL-1:0]      cnt
);
   localparam int HALF = (2**(LVL-1)) - 1;
   localparam int TOP  = 2 * HALF;

   generate
      if (LVL < ones_cnt_pkg::MIN_WIDTH) begin : g_bad
         $error("ones_cnt_node: level below base");
      end else if (LVL == ones_cnt_pkg::MIN_WIDTH) begin : g_base
         // Seven inputs counted by four cells: two triples, then a 2-cell chain.
         logic s_lo, c_lo, s_hi, c_hi, c_mid;
         csa32_cell u_lo  (.a(bits[0]), .b(bits[1]), .c(bits[2]), .s(s_lo), .co(c_lo));
         csa32_cell u_hi  (.a(bits[3]), .b(bits[4]), .c(bits[5]), .s(s_hi), .co(c_hi));
         csa32_cell u_b0  (.a(s_lo), .b(s_hi), .c(bits[6]), .s(cnt[0]), .co(c_mid));
         csa32_cell u_b1  (.a(c_lo), .b(c_hi), .c(c_mid),   .s(cnt[1]), .co(cnt[2]));
      end else begin : g_rec
         logic [LVL-2:0] lo_cnt;
         logic [LVL-2:0] hi_cnt;
         logic [LVL-1:0] rip;

         ones_cnt_node #(.LVL(LVL-1)) u_lo (
            .bits(bits[HALF-1:0]),
            .cnt (lo_cnt)
         );
         ones_cnt_node #(.LVL(LVL-1)) u_hi (
            .bits(bits[TOP-1:HALF]),
            .cnt (hi_cnt)
         );

         // Leftover input enters as carry-in of the lowest chain cell.
         assign rip[0] = bits[TOP];

         for (genvar k = 0; k < LVL-1; k++) begin : g_chain
            csa32_cell u_c (
               .a (lo_cnt[k]),
               .b (hi_cnt[k]),
               .c (rip[k]),
               .s (cnt[k]),
               .co(rip[k+1])
            );
         end

         assign cnt[LVL-1] = rip[LVL-1];
      end
   endgenerate
endmodule

// File: rtl/ones_counter.sv
module ones_counter #(
   parameter int N       = 7,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [(2**N)-2:0]  din,
   output logic [N-1:0]       count
);
   localparam int IN_W  = ones_cnt_pkg::inputs_for(N);
   localparam int CELLS = ones_cnt_pkg::cells_for(N);

   // R7
   if (N < ones_cnt_pkg::MIN_WIDTH || N > ones_cnt_pkg::MAX_WIDTH) begin : g_chk_n
      $error("ones_counter: N out of range");
   end
   if (IN_W != (2**N) - 1 || CELLS < 4) begin : g_chk_w
      $error("ones_counter: derived sizes inconsistent");
   end

   logic [N-1:0] raw_cnt;

   ones_cnt_node #(.LVL(N)) u_tree (
      .bits(din),
      .cnt (raw_cnt)
   );

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) count <= '0;
            else        count <= raw_cnt;
         end

         // R2
         popcount_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (32'(count) == $countones($past(din))));
         // R3
         zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(din) == '0) |-> (count == '0));
         // R4
         full_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && (&$past(din))) |-> (&count));
         // R5
         onehot_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $countones($past(din)) == 1) |-> (count == N'(1)));
      end else begin : g_comb
         assign count = raw_cnt;
      end
   endgenerate
endmodule

// File: tb/ones_counter_test.sv
module ones_counter_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [126:0] din = '0;
   logic [6:0]   cnt7;
   logic [3:0]   cnt4;
   logic [2:0]   cnt3;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      int    e7;
      int    e4;
      int    e3;
      string tag;
   } exp_t;

   exp_t sb[$];

   always #2 clk = ~clk;

   ones_counter #(.N(7)) uut    (.clk(clk), .rst_n(rst_n), .din(din),       .count(cnt7));
   ones_counter #(.N(4)) uut_n4 (.clk(clk), .rst_n(rst_n), .din(din[14:0]), .count(cnt4));
   ones_counter #(.N(3)) uut_n3 (.clk(clk), .rst_n(rst_n), .din(din[6:0]),  .count(cnt3));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Driver: applies a vector at a falling edge and queues its expected counts.
   task automatic drive(input logic [126:0] v, input string tag);
      exp_t e;
      @(negedge clk);
      din  = v;
      e.e7 = $countones(v);
      e.e4 = $countones(v[14:0]);
      e.e3 = $countones(v[6:0]);
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: one item per rising edge after it was driven.
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check({e.tag, " N=7"}, int'(cnt7), e.e7);
         check({e.tag, " N=4 R7"}, int'(cnt4), e.e4);
         check({e.tag, " N=3 R7"}, int'(cnt3), e.e3);
      end
   end

   function automatic logic [126:0] rand_vec();
      logic [127:0] w;
      w = {$urandom(), $urandom(), $urandom(), $urandom()};
      return w[126:0];
   endfunction

   initial begin
      #400000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [126:0] v;
      // R6: reset holds count at zero even with ones on the inputs
      din = '1;
      repeat (3) @(posedge clk);
      #1;
      check("R6 reset", int'(cnt7), 0);
      check("R6 reset N=3", int'(cnt3), 0);
      @(negedge clk);
      din = '0;
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R3
      drive('0, "R3 zero");
      // R4
      drive('1, "R4 ones");
      drive('0, "R3 zero again");
      repeat (2) @(posedge clk);

      // R6: count holds its value until the next rising edge
      drive('1, "R6 latency");
      #1;
      check("R6 hold before edge", int'(cnt7), 0);
      repeat (2) @(posedge clk);

      // R5: single set bit at every position, including the leftover top bit
      for (int i = 0; i < 127; i++) begin
         v = '0;
         v[i] = 1'b1;
         drive(v, "R5 onehot");
      end

      // R1: all 128 patterns of the 7-input counter exercise every cell case
      for (int p = 0; p < 128; p++) begin
         v = '0;
         v[6:0] = 7'(p);
         drive(v, "R1 exhaustive");
      end

      // R2: random vectors and sparse/dense mixes
      for (int r = 0; r < 400; r++) drive(rand_vec(), "R2 random");
      for (int r = 0; r < 100; r++) drive(rand_vec() & rand_vec() & rand_vec(), "R2 sparse");
      for (int r = 0; r < 100; r++) drive(rand_vec() | rand_vec() | rand_vec(), "R2 dense");
      drive({1'b1, 126'b0}, "R5 leftover bit");
      drive({1'b0, {126{1'b1}}}, "R2 all but top");

      repeat (4) @(posedge clk);
      #1;
      check("R2 scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule